// File: doc/BRIEF.md
# Boot Sector Map and Modify Guard

This block sits in front of the program and erase engine of a 2M-word flash array. It takes a 21-bit word address and finds the erase sector that holds it. The array has 67 sectors. Sixty-three are 32K-word sectors. A 32K-word boot region at one end of the array is split into four smaller sectors of 8K, 4K, 4K and 16K words. The parameter `BOOT_TOP` chooses whether that boot region sits at the lowest or the highest addresses.

Sectors are gathered into protection groups. Each group is a run of neighbouring sectors. Each group has one protect bit, held in a register. A set pulse protects the group of the current address. A clear pulse unprotects every group at once.

From these bits and three override inputs (a write-protect level, an accelerate level and a temporary-unprotect level), the block decides whether a modify operation on the addressed sector is allowed. The sector index, the group index and the allow flag are all registered, so each is valid one cycle after the address.

Top module: `boot_sector_guard`

## Requirements
- R1: With `BOOT_TOP`=0, word addresses 0x000000–0x001FFF map to sector 0, 0x002000–0x002FFF to sector 1, 0x003000–0x003FFF to sector 2, and 0x004000–0x007FFF to sector 3. Every other address maps to sector 3 + (address >> 15).
- R2: With `BOOT_TOP`=1, addresses below 0x1F8000 map to sector (address >> 15). Addresses 0x1F8000–0x1FBFFF map to sector 63, 0x1FC000–0x1FCFFF to sector 64, 0x1FD000–0x1FDFFF to sector 65, and 0x1FE000–0x1FFFFF to sector 66.
- R3: Each of the four boot sectors forms a group of its own. The 32K-word sectors are grouped in runs of `GROUP_SPAN` (default 4), starting from the lowest-addressed one. With `BOOT_TOP`=0, groups 0–3 are sectors 0–3, and 32K sector s is in group 4 + (s-4)/4. With `BOOT_TOP`=1, sector s < 63 is in group s/4, and sectors 63–66 are in groups 16–19.
- R4: `sect_idx`, `grp_idx` and `allow_mod` change on the first rising clock edge after the address changes, and not before it.
- R5: While `rst_n` is low, all three outputs read zero and every protect bit is cleared. After reset, with `wp_n` high and no override active, every address is allowed.
- R6: A cycle with `prot_set` high protects the group of the current address. All sectors of that group are then refused, and the other groups are not changed.
- R7: A cycle with `prot_clr_all` high unprotects all groups. If `prot_set` is high in the same cycle, the clear wins.
- R8: When `wp_n` is low and `accel` is low, the four boot sectors are refused whatever their protect bits hold. Sectors outside the boot region are not affected.
- R9: When `accel` is high, every sector is allowed. This overrides both `wp_n` low and stored protect bits, and the protect bits themselves are kept.
- R10: When `temp_unprot` is high, sectors of protected groups are allowed. A boot sector refused by `wp_n` low stays refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 21 | Word address of the intended modify |
| wp_n | input | 1 | Low: boot sectors locked against modify |
| accel | input | 1 | High: all sectors treated as unprotected |
| temp_unprot | input | 1 | High: stored group protection bypassed |
| prot_set | input | 1 | Protect the group holding `addr` |
| prot_clr_all | input | 1 | Unprotect every group |
| sect_idx | output | 7 | Registered sector index, 0–66 |
| grp_idx | output | 5 | Registered protection group index |
| allow_mod | output | 1 | Registered: program or erase permitted |

## Verification
The hardest case to reach is a boot sector whose group bit is already set while `wp_n` is low and `temp_unprot` is high. In that case the two layers disagree, and the write-protect level must win. The stimulus first uses `prot_set` to build a known protection state through the address port. It then applies the override inputs one layer at a time on addresses in the boot region and outside it. Two instances, one with each boot layout, share these inputs. A single sweep of addresses at the sector edges therefore checks both maps against a range-based model.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int ADDR_W   = 21;
  localparam int BIG_LSB  = 15;
  localparam int UNIT_LSB = 12;
  localparam int UNIT_W   = BIG_LSB - UNIT_LSB;
  localparam int PAGE_W   = ADDR_W - UNIT_LSB;
  localparam int NUM_BIG  = 1 << (ADDR_W - BIG_LSB);
  localparam int NUM_BOOT = 4;
  localparam int NUM_SECT = NUM_BIG - 1 + NUM_BOOT;
  localparam int SECT_W   = $clog2(NUM_SECT);

  typedef logic [SECT_W-1:0] sect_t;
  typedef logic [PAGE_W-1:0] page_t;

  // slot 0..3 of a boot sector, counted from the low end of the boot region
  function automatic int boot_slot(input logic [UNIT_W-1:0] u, input bit top);
    int n;
    n = int'(u);
    if (top) begin
      if (n < 4) return 0;
      if (n == 4) return 1;
      if (n == 5) return 2;
      return 3;
    end
    if (n < 2) return 0;
    if (n == 2) return 1;
    if (n == 3) return 2;
    return 3;
  endfunction

  function automatic int sector_of(input page_t p, input bit top);
    int big;
    big = int'(p[PAGE_W-1:UNIT_W]);
    if (top)
      return (big == NUM_BIG - 1) ? NUM_BIG - 1 + boot_slot(p[UNIT_W-1:0], top) : big;
    return (big == 0) ? boot_slot(p[UNIT_W-1:0], top) : big + NUM_BOOT - 1;
  endfunction

  function automatic bit sector_is_boot(input int s, input bit top);
    return top ? (s >= NUM_BIG - 1) : (s < NUM_BOOT);
  endfunction

  function automatic int big_groups(input int span);
    return (NUM_BIG - 1 + span - 1) / span;
  endfunction

  function automatic int group_of(input int s, input bit top, input int span);
    if (top)
      return (s >= NUM_BIG - 1) ? big_groups(span) + s - (NUM_BIG - 1) : s / span;
    return (s < NUM_BOOT) ? s : NUM_BOOT + (s - NUM_BOOT) / span;
  endfunction
endpackage

// File: rtl/bsm_sector_decode.sv
module bsm_sector_decode
  import bsm_pkg::*;
  #(parameter bit BOOT_TOP = 1'b0,
    parameter int GROUP_SPAN = 4,
    parameter int GRP_W = 5)
  (input  page_t            page,
   output sect_t            sect,
   output logic [GRP_W-1:0] grp,
   output logic             boot);

  int s_num;

  always_comb begin
    s_num = sector_of(page, BOOT_TOP);
    sect  = sect_t'(s_num);
    grp   = GRP_W'(group_of(s_num, BOOT_TOP, GROUP_SPAN));
    boot  = sector_is_boot(s_num, BOOT_TOP);
  end
endmodule

// File: rtl/bsm_group_bits.sv
module bsm_group_bits
  #(parameter int NUM_GRP = 20,
    parameter int GRP_W = 5)
  (input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_all,
   input  logic [GRP_W-1:0]   set_grp,
   output logic [NUM_GRP-1:0] prot_q);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        prot_q[g] <= 1'b0;
      else if (clr_all)
        prot_q[g] <= 1'b0;
      else if (set_en && set_grp == GRP_W'(g))
        prot_q[g] <= 1'b1;
    end
  end

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> prot_q == '0);

  // R6
  set_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_all) |=> prot_q[$past(set_grp)]);

  // R6
  set_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_all) |=> $countones(prot_q) >= $countones($past(prot_q)));
endmodule

// File: rtl/bsm_modify_gate.sv
module bsm_modify_gate
  import bsm_pkg::*;
  #(parameter int NUM_GRP = 20,
    parameter int GRP_W = 5)
  (input  logic               clk,
   input  logic               rst_n,
   input  sect_t              sect,
   input  logic [GRP_W-1:0]   grp,
   input  logic               boot,
   input  logic [NUM_GRP-1:0] prot_q,
   input  logic               wp_n,
   input  logic               accel,
   input  logic               temp_unprot,
   output sect_t              sect_q,
   output logic [GRP_W-1:0]   grp_q,
   output logic               allow_q);

  logic wp_block;
  logic grp_locked;
  logic allow_d;

  assign wp_block   = boot & ~wp_n;
  assign grp_locked = prot_q[grp] & ~temp_unprot;
  assign allow_d    = accel | ~(wp_block | grp_locked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sect_q  <= '0;
      grp_q   <= '0;
      allow_q <= 1'b0;
    end else begin
      sect_q  <= sect;
      grp_q   <= grp;
      allow_q <= allow_d;
    end
  end

  // R9
  accel_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accel |=> allow_q);

  // R8
  wp_boot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accel && !wp_n && boot) |=> !allow_q);

  // R10
  temp_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accel && temp_unprot && !(boot && !wp_n)) |=> allow_q);

  // R1
  sect_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_q < sect_t'(NUM_SECT));
endmodule

// File: rtl/boot_sector_guard.sv
module boot_sector_guard
  import bsm_pkg::*;
  #(parameter bit BOOT_TOP = 1'b0,
    parameter int GROUP_SPAN = 4,
    localparam int NUM_GRP = NUM_BOOT + big_groups(GROUP_SPAN),
    localparam int GRP_W = $clog2(NUM_GRP))
  (input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wp_n,
   input  logic              accel,
   input  logic              temp_unprot,
   input  logic              prot_set,
   input  logic              prot_clr_all,
   output logic [SECT_W-1:0] sect_idx,
   output logic [GRP_W-1:0]  grp_idx,
   output logic              allow_mod);

  sect_t              dec_sect;
  logic [GRP_W-1:0]   dec_grp;
  logic               dec_boot;
  logic [NUM_GRP-1:0] prot_bits;
  logic               unused_low;

  assign unused_low = ^addr[UNIT_LSB-1:0];

  bsm_sector_decode #(.BOOT_TOP(BOOT_TOP), .GROUP_SPAN(GROUP_SPAN), .GRP_W(GRP_W)) u_dec (
    .page (addr[ADDR_W-1:UNIT_LSB]),
    .sect (dec_sect),
    .grp  (dec_grp),
    .boot (dec_boot));

  bsm_group_bits #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (prot_set),
    .clr_all (prot_clr_all),
    .set_grp (dec_grp),
    .prot_q  (prot_bits));

  bsm_modify_gate #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .sect        (dec_sect),
    .grp         (dec_grp),
    .boot        (dec_boot),
    .prot_q      (prot_bits),
    .wp_n        (wp_n),
    .accel       (accel),
    .temp_unprot (temp_unprot),
    .sect_q      (sect_idx),
    .grp_q       (grp_idx),
    .allow_q     (allow_mod));
endmodule

// File: tb/boot_sector_guard_test.sv
module boot_sector_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] addr_i = '0;
  logic        wp_n_i = 1'b1, accel_i = 1'b0, temp_i = 1'b0, set_i = 1'b0, clr_i = 1'b0;
  logic [6:0]  sect_b, sect_t;
  logic [4:0]  grp_b, grp_t;
  logic        allow_b, allow_t;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sector_guard #(.BOOT_TOP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr_i), .wp_n(wp_n_i), .accel(accel_i),
    .temp_unprot(temp_i), .prot_set(set_i), .prot_clr_all(clr_i),
    .sect_idx(sect_b), .grp_idx(grp_b), .allow_mod(allow_b));

  boot_sector_guard #(.BOOT_TOP(1'b1)) uut_top (
    .clk(clk), .rst_n(rst_n), .addr(addr_i), .wp_n(wp_n_i), .accel(accel_i),
    .temp_unprot(temp_i), .prot_set(set_i), .prot_clr_all(clr_i),
    .sect_idx(sect_t), .grp_idx(grp_t), .allow_mod(allow_t));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // range-based reference maps
  function automatic int m_sect(input logic [20:0] a, input bit top);
    if (!top) begin
      if (a < 21'h002000) return 0;
      if (a < 21'h003000) return 1;
      if (a < 21'h004000) return 2;
      if (a < 21'h008000) return 3;
      return 3 + int'(a / 21'h008000);
    end
    if (a < 21'h1F8000) return int'(a / 21'h008000);
    if (a < 21'h1FC000) return 63;
    if (a < 21'h1FD000) return 64;
    if (a < 21'h1FE000) return 65;
    return 66;
  endfunction

  function automatic int m_grp(input int s, input bit top);
    if (!top) return (s <= 3) ? s : 4 + (s - 4) / 4;
    return (s >= 63) ? s - 47 : s / 4;
  endfunction

  task automatic step(input logic [20:0] a, input bit s, input bit c);
    @(negedge clk);
    addr_i = a; set_i = s; clr_i = c;
    @(negedge clk);
    set_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R5 sect in reset", int'(sect_b), 0);
    chk("R5 grp in reset", int'(grp_t), 0);
    chk("R5 allow in reset", int'(allow_b), 0);
    rst_n = 1'b1;
    step(21'h000000, 0, 0);
    chk("R5 bottom allow after reset", int'(allow_b), 1);
    chk("R5 top allow after reset", int'(allow_t), 1);
    step(21'h1FFFFF, 0, 0);
    chk("R5 bottom allow high end", int'(allow_b), 1);
    chk("R5 top allow high end", int'(allow_t), 1);
  endtask

  task automatic t_map();
    logic [20:0] pts [14] = '{21'h000000, 21'h001FFF, 21'h002000, 21'h002FFF,
                              21'h003000, 21'h004000, 21'h007FFF, 21'h008000,
                              21'h020000, 21'h1F7FFF, 21'h1F8000, 21'h1FC800,
                              21'h1FD000, 21'h1FFFFF};
    foreach (pts[i]) begin
      step(pts[i], 0, 0);
      chk("R1 bottom sector", int'(sect_b), m_sect(pts[i], 1'b0));
      chk("R2 top sector", int'(sect_t), m_sect(pts[i], 1'b1));
      chk("R3 bottom group", int'(grp_b), m_grp(m_sect(pts[i], 1'b0), 1'b0));
      chk("R3 top group", int'(grp_t), m_grp(m_sect(pts[i], 1'b1), 1'b1));
    end
  endtask

  task automatic t_latency();
    step(21'h008000, 0, 0);
    @(negedge clk);
    addr_i = 21'h010000;
    #1;
    chk("R4 sector before edge", int'(sect_b), 4);
    @(negedge clk);
    chk("R4 sector after edge", int'(sect_b), 5);
  endtask

  task automatic t_protect();
    step(21'h008000, 1, 0);
    step(21'h020000, 0, 0);
    chk("R6 bottom S7 same group refused", int'(allow_b), 0);
    chk("R6 top S4 other group allowed", int'(allow_t), 1);
    step(21'h028000, 0, 0);
    chk("R6 bottom S8 next group allowed", int'(allow_b), 1);
    step(21'h000000, 0, 0);
    chk("R6 top S0 group refused", int'(allow_t), 0);
    chk("R6 bottom S0 untouched", int'(allow_b), 1);
  endtask

  task automatic t_clear();
    step(21'h040000, 1, 1);
    step(21'h020000, 0, 0);
    chk("R7 bottom earlier group cleared", int'(allow_b), 1);
    step(21'h040000, 0, 0);
    chk("R7 clear beats set", int'(allow_b), 1);
    step(21'h000000, 0, 0);
    chk("R7 top group cleared", int'(allow_t), 1);
  endtask

  task automatic t_wp();
    wp_n_i = 1'b0;
    step(21'h005000, 0, 0);
    chk("R8 bottom boot refused", int'(allow_b), 0);
    chk("R8 top S0 unaffected", int'(allow_t), 1);
    step(21'h1FF000, 0, 0);
    chk("R8 top boot refused", int'(allow_t), 0);
    chk("R8 bottom S66 unaffected", int'(allow_b), 1);
    wp_n_i = 1'b1;
  endtask

  task automatic t_accel();
    step(21'h020000, 1, 0);
    wp_n_i = 1'b0; accel_i = 1'b1;
    step(21'h020000, 0, 0);
    chk("R9 protected group opened bottom", int'(allow_b), 1);
    chk("R9 protected group opened top", int'(allow_t), 1);
    step(21'h005000, 0, 0);
    chk("R9 wp boot opened", int'(allow_b), 1);
    accel_i = 1'b0; wp_n_i = 1'b1;
    step(21'h020000, 0, 0);
    chk("R9 protect bit retained", int'(allow_b), 0);
  endtask

  task automatic t_temp();
    temp_i = 1'b1;
    step(21'h020000, 0, 0);
    chk("R10 temp opens bottom group", int'(allow_b), 1);
    chk("R10 temp opens top group", int'(allow_t), 1);
    step(21'h002000, 1, 0);
    wp_n_i = 1'b0;
    step(21'h002000, 0, 0);
    chk("R10 wp boot stays refused", int'(allow_b), 0);
    step(21'h020000, 0, 0);
    chk("R10 non-boot open with wp low", int'(allow_b), 1);
    wp_n_i = 1'b1; temp_i = 1'b0;
    step(21'h020000, 0, 0);
    chk("R10 lock returns", int'(allow_b), 0);
    step(21'h000000, 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_map();
    t_latency();
    t_protect();
    t_clear();
    t_wp();
    t_accel();
    t_temp();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule